// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads a page directory entry and then a page table entry through a simple memory port that uses a request and acknowledge handshake. The caller supplies the linear address, the base address of the directory, whether the requester is user or supervisor, whether the access writes (a read-modify-write counts as a write), whether it is an instruction fetch, and whether no-execute protection is enabled.

During the walk the block sets the accessed bit of each entry it uses. On a write it also sets the dirty bit of the table entry. It then checks access rights against the AND of both entries' flag bits. Every accepted request ends in exactly one `done` pulse. That pulse carries either a valid physical address or a fault with a five-bit error code. On a fault the block also captures the faulting linear address in a register, which keeps its value until the next fault.

A processor core's memory pipeline uses the block when its translation cache misses. It issues one `start` and waits for `done` before it issues another.

Top module: `l2w_walker`

## Requirements
- R1: After reset, `done`, `busy`, `mem_req`, `phys_ok` and `fault` are low and `fault_addr` is zero.
- R2: The directory entry is read at `dir_base + lin_addr[31:22]*4`. The table entry is read at `{pde[31:12], lin_addr[21:12], 2'b00}`. Entries are 32-bit words.
- R3: If bit 0 (present) is clear in the directory entry or the table entry, the walk ends in a fault with error code bit 0 equal to 0. A non-present directory entry stops the walk before any table read.
- R4: A present directory entry with bit 5 (accessed) clear is written back with bit 5 set. A present table entry that passes the permission check is written back with bit 5 set, and with bit 6 (dirty) set on a write, whenever either of those bits needs changing. An entry that needs no change is never written.
- R5: A supervisor access to a present page is always allowed. A user access needs bit 2 (user) set in both entries. A user write also needs bit 1 (writable) set in both entries. Any other case faults with error code bit 0 equal to 1.
- R6: Error code bit 1 equals the effective write flag. Bit 2 equals 1 for a user requester. Bit 3 (reserved-bit violation) is always 0.
- R7: Error code bit 4 is 1 only when `nx_en` is high and the access is an instruction fetch. A fetch is always treated as a read, whatever the value of `wr_req`.
- R8: On success, `phys_ok` is high with `done` and `phys_addr = {pte[31:12], lin_addr[11:0]}`.
- R9: On every fault, `fault_addr` takes the faulting linear address in the same cycle that `done` rises. A successful walk leaves `fault_addr` unchanged.
- R10: Each accepted `start` produces exactly one single-cycle `done`, with exactly one of `phys_ok` and `fault` high. A `start` that arrives while `busy` is high is ignored.
- R11: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until the cycle in which `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk; sampled only while idle |
| lin_addr | input | 32 | Linear address to translate |
| user_req | input | 1 | 1 = user requester, 0 = supervisor |
| wr_req | input | 1 | Write or read-modify-write access |
| fetch_req | input | 1 | Instruction fetch access |
| nx_en | input | 1 | No-execute protection enabled |
| dir_base | input | 32 | Physical base address of the page directory |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| phys_ok | output | 1 | Translation succeeded (with `done`) |
| phys_addr | output | 32 | Translated physical address |
| fault | output | 1 | Page fault (with `done`) |
| err_code | output | 5 | Fault error code |
| fault_addr | output | 32 | Linear address of the most recent fault |

## Verification
A wrong state in the walker shows up at the ports within one walk. A wrong index or frame register reads the wrong word, so the next `done` carries the wrong physical address or a false not-present fault. A stale flag register gives a wrong protection result or wrong error code bits in that same `done` pulse. A mishandled update decision shows up as a missing or extra memory write. The bench sees this in its memory model as an entry whose accessed or dirty bits are wrong, or as a changed write count, right after the pulse. A control-state error shows up as a missing or doubled `done`, or as a request that changes before it is acknowledged. The scoreboard catches the first case as an empty queue or a timeout, and the bound checker catches the second in the cycle it happens.

// File: rtl/l2w_pkg.sv
package l2w_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_RD_DIR,
      S_CK_DIR,
      S_WR_DIR,
      S_RD_TBL,
      S_CK_TBL,
      S_WR_TBL,
      S_OK,
      S_FLT
   } walk_st_e;

   // entry flag positions; the permission and update logic decode these
   localparam int unsigned FLG_PRES  = 0;
   localparam int unsigned FLG_WRITE = 1;
   localparam int unsigned FLG_USER  = 2;
   localparam int unsigned FLG_ACC   = 5;
   localparam int unsigned FLG_DIRTY = 6;

   localparam int unsigned EC_W = 5;

   // packed error code, MSB first: bit4 .. bit0
   typedef struct packed {
      logic nx_fetch;
      logic rsvd;
      logic user;
      logic wr;
      logic prot;
   } err_t;

endpackage

// File: rtl/l2w_perm.sv
module l2w_perm #(
   parameter bit SUP_WP = 1'b0
) (
   input  logic user,
   input  logic wr,
   input  logic u_comb,
   input  logic w_comb,
   output logic allow
);

   logic sup_allow;
   logic usr_allow;

   generate
      if (SUP_WP) begin : g_sup_wp
         assign sup_allow = !wr || w_comb;
      end else begin : g_sup_free
         assign sup_allow = 1'b1;
      end
   endgenerate

   assign usr_allow = u_comb && (!wr || w_comb);
   assign allow     = user ? usr_allow : sup_allow;

endmodule

// File: rtl/l2w_errcode.sv
module l2w_errcode
   import l2w_pkg::*;
(
   input  logic            prot,
   input  logic            wr,
   input  logic            user,
   input  logic            fetch,
   input  logic            nx_en,
   output logic [EC_W-1:0] code
);

   err_t ec;

   always_comb begin
      ec.prot     = prot;
      ec.wr       = wr;
      ec.user     = user;
      ec.rsvd     = 1'b0;
      ec.nx_fetch = nx_en && fetch;
   end

   assign code = ec;

endmodule

// File: rtl/l2w_ctrl.sv
module l2w_ctrl
   import l2w_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = 10,
   parameter int unsigned OFF_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] lin_addr,
   input  logic              user_req,
   input  logic              wr_req,
   input  logic              fetch_req,
   input  logic              nx_en,
   input  logic [ADDR_W-1:0] dir_base,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [ADDR_W-1:0] mem_rdata,
   input  logic              perm_ok,
   input  logic [EC_W-1:0]   err_in,
   output logic              prot_o,
   output logic              user_o,
   output logic              wr_o,
   output logic              fetch_o,
   output logic              nx_o,
   output logic              u_comb,
   output logic              w_comb,
   output logic              busy,
   output logic              done,
   output logic              phys_ok,
   output logic [ADDR_W-1:0] phys_addr,
   output logic              fault,
   output logic [EC_W-1:0]   err_code,
   output logic [ADDR_W-1:0] fault_addr
);

   localparam int unsigned ENT_BYTES = ADDR_W / 8;
   localparam int unsigned ENT_SH    = $clog2(ENT_BYTES);
   localparam int unsigned FRAME_W   = ADDR_W - OFF_W;

   localparam logic [ADDR_W-1:0] ACC_MASK = ADDR_W'(1) << FLG_ACC;
   localparam logic [ADDR_W-1:0] DRT_MASK = ADDR_W'(1) << FLG_DIRTY;

   walk_st_e          st;
   logic [ADDR_W-1:0] la_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] pde_q;
   logic [ADDR_W-1:0] pte_q;
   logic              usr_q;
   logic              wr_q;
   logic              fch_q;
   logic              nx_q;
   logic [EC_W-1:0]   err_q;
   logic [ADDR_W-1:0] fa_q;

   logic [IDX_W-1:0]  dir_idx;
   logic [IDX_W-1:0]  tbl_idx;
   logic [ADDR_W-1:0] dir_addr;
   logic [ADDR_W-1:0] tbl_addr;
   logic              pte_upd;
   logic [ADDR_W-1:0] pte_new;

   assign dir_idx  = la_q[ADDR_W-1 -: IDX_W];
   assign tbl_idx  = la_q[OFF_W +: IDX_W];
   assign dir_addr = base_q + (ADDR_W'(dir_idx) << ENT_SH);
   assign tbl_addr = {pde_q[ADDR_W-1 -: FRAME_W], tbl_idx, {ENT_SH{1'b0}}};

   assign u_comb   = pde_q[FLG_USER]  && pte_q[FLG_USER];
   assign w_comb   = pde_q[FLG_WRITE] && pte_q[FLG_WRITE];
   assign pte_upd  = !pte_q[FLG_ACC] || (wr_q && !pte_q[FLG_DIRTY]);
   assign pte_new  = pte_q | ACC_MASK | (wr_q ? DRT_MASK : '0);

   assign prot_o   = (st == S_CK_TBL) && pte_q[FLG_PRES];
   assign user_o   = usr_q;
   assign wr_o     = wr_q;
   assign fetch_o  = fch_q;
   assign nx_o     = nx_q;

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (st)
         S_RD_DIR: begin
            mem_req  = 1'b1;
            mem_addr = dir_addr;
         end
         S_WR_DIR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = dir_addr;
            mem_wdata = pde_q | ACC_MASK;
         end
         S_RD_TBL: begin
            mem_req  = 1'b1;
            mem_addr = tbl_addr;
         end
         S_WR_TBL: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = tbl_addr;
            mem_wdata = pte_new;
         end
         default: begin
            mem_req = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         la_q   <= '0;
         base_q <= '0;
         pde_q  <= '0;
         pte_q  <= '0;
         usr_q  <= 1'b0;
         wr_q   <= 1'b0;
         fch_q  <= 1'b0;
         nx_q   <= 1'b0;
         err_q  <= '0;
         fa_q   <= '0;
      end else begin
         unique case (st)
            S_IDLE: begin
               if (start) begin
                  la_q   <= lin_addr;
                  base_q <= dir_base;
                  usr_q  <= user_req;
                  wr_q   <= wr_req && !fetch_req;
                  fch_q  <= fetch_req;
                  nx_q   <= nx_en;
                  pde_q  <= '0;
                  pte_q  <= '0;
                  st     <= S_RD_DIR;
               end
            end
            S_RD_DIR: begin
               if (mem_ack) begin
                  pde_q <= mem_rdata;
                  st    <= S_CK_DIR;
               end
            end
            S_CK_DIR: begin
               if (!pde_q[FLG_PRES]) begin
                  err_q <= err_in;
                  fa_q  <= la_q;
                  st    <= S_FLT;
               end else if (!pde_q[FLG_ACC]) begin
                  st <= S_WR_DIR;
               end else begin
                  st <= S_RD_TBL;
               end
            end
            S_WR_DIR: begin
               if (mem_ack) begin
                  st <= S_RD_TBL;
               end
            end
            S_RD_TBL: begin
               if (mem_ack) begin
                  pte_q <= mem_rdata;
                  st    <= S_CK_TBL;
               end
            end
            S_CK_TBL: begin
               if (!pte_q[FLG_PRES] || !perm_ok) begin
                  err_q <= err_in;
                  fa_q  <= la_q;
                  st    <= S_FLT;
               end else if (pte_upd) begin
                  st <= S_WR_TBL;
               end else begin
                  st <= S_OK;
               end
            end
            S_WR_TBL: begin
               if (mem_ack) begin
                  st <= S_OK;
               end
            end
            default: begin
               st <= S_IDLE;
            end
         endcase
      end
   end

   assign busy       = (st != S_IDLE);
   assign done       = (st == S_OK) || (st == S_FLT);
   assign phys_ok    = (st == S_OK);
   assign fault      = (st == S_FLT);
   assign phys_addr  = {pte_q[ADDR_W-1 -: FRAME_W], la_q[OFF_W-1:0]};
   assign err_code   = err_q;
   assign fault_addr = fa_q;

endmodule

// File: rtl/l2w_walker.sv
module l2w_walker
   import l2w_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = 10,
   parameter int unsigned OFF_W  = 12,
   parameter bit          SUP_WP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] lin_addr,
   input  logic              user_req,
   input  logic              wr_req,
   input  logic              fetch_req,
   input  logic              nx_en,
   input  logic [ADDR_W-1:0] dir_base,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [ADDR_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              phys_ok,
   output logic [ADDR_W-1:0] phys_addr,
   output logic              fault,
   output logic [EC_W-1:0]   err_code,
   output logic [ADDR_W-1:0] fault_addr
);

   localparam int unsigned ENT_SH = $clog2(ADDR_W / 8);

   generate
      if (ADDR_W != 2 * IDX_W + OFF_W) begin : g_bad_split
         $error("l2w_walker: address split does not cover ADDR_W");
      end
      if (OFF_W != IDX_W + ENT_SH) begin : g_bad_table
         $error("l2w_walker: one table must fill exactly one page");
      end
      if (ADDR_W % 8 != 0 || ADDR_W < 16) begin : g_bad_width
         $error("l2w_walker: ADDR_W must be a byte multiple of at least 16");
      end
   endgenerate

   logic            perm_ok;
   logic [EC_W-1:0] err_in;
   logic            prot_w;
   logic            user_w;
   logic            wr_w;
   logic            fetch_w;
   logic            nx_w;
   logic            u_comb;
   logic            w_comb;

   l2w_ctrl #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .OFF_W  (OFF_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .lin_addr   (lin_addr),
      .user_req   (user_req),
      .wr_req     (wr_req),
      .fetch_req  (fetch_req),
      .nx_en      (nx_en),
      .dir_base   (dir_base),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .perm_ok    (perm_ok),
      .err_in     (err_in),
      .prot_o     (prot_w),
      .user_o     (user_w),
      .wr_o       (wr_w),
      .fetch_o    (fetch_w),
      .nx_o       (nx_w),
      .u_comb     (u_comb),
      .w_comb     (w_comb),
      .busy       (busy),
      .done       (done),
      .phys_ok    (phys_ok),
      .phys_addr  (phys_addr),
      .fault      (fault),
      .err_code   (err_code),
      .fault_addr (fault_addr)
   );

   l2w_perm #(
      .SUP_WP (SUP_WP)
   ) u_perm (
      .user   (user_w),
      .wr     (wr_w),
      .u_comb (u_comb),
      .w_comb (w_comb),
      .allow  (perm_ok)
   );

   l2w_errcode u_ec (
      .prot  (prot_w),
      .wr    (wr_w),
      .user  (user_w),
      .fetch (fetch_w),
      .nx_en (nx_w),
      .code  (err_in)
   );

endmodule

// File: rtl/l2w_walker_chk.sv
module l2w_walker_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [ADDR_W-1:0] lin_addr,
   input logic              fetch_req,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] mem_wdata,
   input logic              mem_ack,
   input logic              busy,
   input logic              done,
   input logic              phys_ok,
   input logic              fault,
   input logic [4:0]        err_code,
   input logic [ADDR_W-1:0] fault_addr
);

   logic [ADDR_W-1:0] cap_lin;
   logic              cap_fetch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_lin   <= '0;
         cap_fetch <= 1'b0;
      end else if (start && !busy) begin
         cap_lin   <= lin_addr;
         cap_fetch <= fetch_req;
      end
   end

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req && !done);

   // R10
   one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (phys_ok != fault));

   // R6
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && fault |-> !err_code[3]);

   // R9
   fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && fault |-> fault_addr == cap_lin);

   // R7
   fetch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && fault && cap_fetch |-> !err_code[1]);

   // R4
   wb_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_wdata[5]);

endmodule

bind l2w_walker l2w_walker_chk #(.ADDR_W(ADDR_W)) u_walker_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .lin_addr   (lin_addr),
   .fetch_req  (fetch_req),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_ack    (mem_ack),
   .busy       (busy),
   .done       (done),
   .phys_ok    (phys_ok),
   .fault      (fault),
   .err_code   (err_code),
   .fault_addr (fault_addr)
);

// File: tb/test_l2w_walker.sv
module test_l2w_walker;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] lin_addr = '0;
   logic        user_req = 1'b0;
   logic        wr_req = 1'b0;
   logic        fetch_req = 1'b0;
   logic        nx_en = 1'b0;
   logic [31:0] dir_base = '0;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        busy;
   logic        done;
   logic        phys_ok;
   logic [31:0] phys_addr;
   logic        fault;
   logic [4:0]  err_code;
   logic [31:0] fault_addr;

   always #(CLK_PERIOD / 2) clk = ~clk;

   l2w_walker i_l2w_walker (
      .clk(clk), .rst_n(rst_n), .start(start), .lin_addr(lin_addr),
      .user_req(user_req), .wr_req(wr_req), .fetch_req(fetch_req), .nx_en(nx_en),
      .dir_base(dir_base), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy),
      .done(done), .phys_ok(phys_ok), .phys_addr(phys_addr), .fault(fault),
      .err_code(err_code), .fault_addr(fault_addr)
   );

   // memory model: word array, one-cycle acknowledge
   logic [31:0] mem [0:2047];
   int          wr_cnt = 0;

   always @(posedge clk) begin
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_we) begin
            mem[mem_addr[12:2]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
         end else begin
            mem_rdata <= mem[mem_addr[12:2]];
         end
      end else begin
         mem_ack <= 1'b0;
      end
   end

   // scoreboard
   typedef struct {
      logic [31:0] la;
      logic        ok;
      logic [31:0] pa;
      logic [4:0]  ec;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   int          total = 0;
   int          bad = 0;
   int          done_cnt = 0;
   logic [31:0] exp_fa = '0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && done) begin
         done_cnt++;
         if (sb_q.size() == 0) begin
            check("R10 unexpected done", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.tag, " phys_ok"}, {31'd0, phys_ok}, {31'd0, e.ok});
            check({e.tag, " fault"}, {31'd0, fault}, {31'd0, !e.ok});
            if (e.ok) begin
               check({e.tag, " phys_addr"}, phys_addr, e.pa);
            end else begin
               check({e.tag, " err_code"}, {27'd0, err_code}, {27'd0, e.ec});
               exp_fa = e.la;
            end
            // R9: holds across successes, updates on faults
            check({e.tag, " R9 fault_addr"}, fault_addr, exp_fa);
         end
      end
   end

   task automatic walk(input logic [31:0] la, input bit u, input bit w, input bit f,
                       input bit nx, input bit ok, input logic [31:0] pa,
                       input logic [4:0] ec, input string tag);
      exp_t e;
      int   prev;
      e.la = la; e.ok = ok; e.pa = pa; e.ec = ec; e.tag = tag;
      sb_q.push_back(e);
      prev = done_cnt;
      @(negedge clk);
      lin_addr = la; user_req = u; wr_req = w; fetch_req = f; nx_en = nx;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait (done_cnt == prev + 1);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int base_wr;
      int prev;
      for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
      mem[0]     = 32'h0000_1007;  // P W U, accessed clear
      mem[1]     = 32'h0000_1025;  // P U A, not writable
      mem[2]     = 32'h0000_1003;  // P W, supervisor only
      mem[3]     = 32'h0000_0000;  // not present
      mem[12'h400] = 32'hABCD_E007; // P W U
      mem[12'h401] = 32'h1234_5000; // not present
      mem[12'h402] = 32'h5555_5067; // P W U A D
      mem[12'h403] = 32'h7777_7025; // P U A

      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 done", {31'd0, done}, 32'd0);
      check("R1 busy", {31'd0, busy}, 32'd0);
      check("R1 mem_req", {31'd0, mem_req}, 32'd0);
      check("R1 fault_addr", fault_addr, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R8 user read; R4 both accessed bits written
      walk(32'h0000_0123, 1, 0, 0, 0, 1, 32'hABCD_E123, 5'h00, "R8 user read");
      check("R4 pde accessed", mem[0], 32'h0000_1027);
      check("R4 pte accessed", mem[12'h400], 32'hABCD_E027);

      // R4 write sets dirty
      walk(32'h0000_0456, 1, 1, 0, 0, 1, 32'hABCD_E456, 5'h00, "R2 user write");
      check("R4 pte dirty", mem[12'h400], 32'hABCD_E067);

      // R3 table entry not present
      walk(32'h0000_1000, 1, 0, 0, 0, 0, 32'h0, 5'h04, "R3 pte absent");
      // R3 directory entry not present, user write
      base_wr = wr_cnt;
      walk(32'h00C0_0008, 1, 1, 0, 0, 0, 32'h0, 5'h06, "R3 pde absent");
      check("R3 no write on absent pde", base_wr, wr_cnt);

      // R5 user write to read-only page
      walk(32'h0040_2010, 1, 1, 0, 0, 0, 32'h0, 5'h07, "R5 user ro write");
      // R5 supervisor write ignores writable bit; R4 no write needed
      base_wr = wr_cnt;
      walk(32'h0040_2010, 0, 1, 0, 0, 1, 32'h5555_5010, 5'h00, "R5 sup write");
      check("R4 no redundant write", wr_cnt, base_wr);
      walk(32'h0040_3044, 0, 1, 0, 0, 1, 32'h7777_7044, 5'h00, "R5 sup write ro");
      check("R4 dirty on sup write", mem[12'h403], 32'h7777_7065);

      // R5 R6 user read of supervisor page
      walk(32'h0080_2020, 1, 0, 0, 0, 0, 32'h0, 5'h05, "R6 user on sup page");
      check("R4 pde2 accessed", mem[2], 32'h0000_1023);
      // supervisor fetch succeeds, fault_addr held
      walk(32'h0080_3ABC, 0, 0, 1, 1, 1, 32'h7777_7ABC, 5'h00, "R8 sup fetch");
      // R7 fetch id bit gated by nx_en
      walk(32'h0080_0000, 1, 0, 1, 1, 0, 32'h0, 5'h15, "R7 fetch nx on");
      walk(32'h0080_0000, 1, 0, 1, 0, 0, 32'h0, 5'h05, "R7 fetch nx off");
      // R7 fetch with write flag treated as read
      walk(32'h0000_1000, 1, 1, 1, 1, 0, 32'h0, 5'h14, "R7 fetch ignores wr");

      // R10 start while busy ignored
      begin
         exp_t e;
         e.la = 32'h0000_2020; e.ok = 1; e.pa = 32'h5555_5020; e.ec = 5'h0;
         e.tag = "R10 busy start";
         sb_q.push_back(e);
         prev = done_cnt;
         @(negedge clk);
         lin_addr = 32'h0000_2020; user_req = 0; wr_req = 0; fetch_req = 0; nx_en = 0;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         @(negedge clk);
         lin_addr = 32'h00C0_0008; user_req = 1; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (20) @(negedge clk);
         check("R10 single done", done_cnt, prev + 1);
         check("R10 busy released", {31'd0, busy}, 32'd0);
      end

      check("R10 scoreboard drained", sb_q.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule